// File: doc/BRIEF.md
# Bidirectional Four-Bit Shift Register

This block is a small register of four cells that, on each rising clock edge, either keeps its contents, moves them one place toward the right end, moves them one place toward the left end, or takes a four-bit word in parallel. A two-bit mode input selects the operation. A synchronous clear input overrides the mode and empties the register. Clear is also the only way to bring the register to a known value after power-up.

Each end of the register has its own serial input and its own serial output, so the block can be chained in either direction. It can serialise a parallel word, collect a serial stream into a word, or act as a small delay line. The full contents are always visible on a parallel output. Each cell picks its next value through its own four-way selector, and clear forces that selector's output to zero.

Top module: `bidir_shift_reg`

## Requirements
- R1: The contents change only at a rising clock edge. An input change between edges leaves every output unchanged until the next rising edge.
- R2: When mode is 2'b00 (keep) and clear is low, the contents stay as they are.
- R3: When mode is 2'b01 (move right) and clear is low, each cell takes the old value of the cell to its left. The leftmost cell, bit 3, takes `ser_left_in`.
- R4: When mode is 2'b10 (move left) and clear is low, each cell takes the old value of the cell to its right. The rightmost cell, bit 0, takes `ser_right_in`.
- R5: When mode is 2'b11 (parallel take) and clear is low, all four cells take `par_in` in the same edge.
- R6: When clear is high at a rising edge, the register becomes 4'b0000 whatever the mode. This is the reset path.
- R7: `ser_left_out` always equals the leftmost cell (bit 3), and `ser_right_out` always equals the rightmost cell (bit 0).
- R8: `par_out` always presents all four cells, with bit 3 as the leftmost cell. Over any mixed sequence of modes, clears and data, it matches a model built from R2 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear, overrides mode |
| mode | input | 2 | 00 keep, 01 move right, 10 move left, 11 parallel take |
| ser_left_in | input | 1 | Serial input entering at the left end (bit 3) |
| ser_right_in | input | 1 | Serial input entering at the right end (bit 0) |
| par_in | input | 4 | Parallel input word |
| par_out | output | 4 | Current contents, bit 3 leftmost |
| ser_left_out | output | 1 | Leftmost cell |
| ser_right_out | output | 1 | Rightmost cell |

## Verification
All outputs come straight from the cells, so a wrong cell value shows on `par_out` in the same cycle it is stored. One more move carries it to a serial output. A neighbour link wired the wrong way shows after a single move: the bit pattern appears mirrored, or one bit is duplicated. A fault in the clear path or in the parallel take shows on the first edge that uses it. The bench therefore compares the output after every edge, so any such fault is caught within one cycle of the faulty operation.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [1:0] {
        BSR_KEEP  = 2'b00,
        BSR_RIGHT = 2'b01,
        BSR_LEFT  = 2'b10,
        BSR_TAKE  = 2'b11
    } bsr_mode_e;

endpackage

// File: rtl/bsr_cell_next.sv
module bsr_cell_next
    import bsr_pkg::*;
(
    input  logic      clr,
    input  bsr_mode_e mode,
    input  logic      own_bit,
    input  logic      from_left,
    input  logic      from_right,
    input  logic      load_bit,
    output logic      next_bit
);

    logic pick;

    always_comb begin
        unique case (mode)
            BSR_KEEP:  pick = own_bit;
            BSR_RIGHT: pick = from_left;
            BSR_LEFT:  pick = from_right;
            BSR_TAKE:  pick = load_bit;
            default:   pick = own_bit;
        endcase
        next_bit = pick & ~clr;
    end

endmodule

// File: rtl/bsr_state.sv
module bsr_state #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] cells_in,
    output logic [WIDTH-1:0] cells_out
);

    typedef struct packed {
        logic [WIDTH-1:0] cells;
    } state_t;

    state_t st_d;
    state_t st_q;

    always_comb begin
        st_d       = st_q;
        st_d.cells = cells_in;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cells_out = st_q.cells;

endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
    import bsr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [1:0]       mode,
    input  logic             ser_left_in,
    input  logic             ser_right_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] par_out,
    output logic             ser_left_out,
    output logic             ser_right_out
);

    localparam int MSB = WIDTH - 1;

    bsr_mode_e        mode_e;
    logic [WIDTH-1:0] cells_q;
    logic [WIDTH-1:0] cells_d;
    logic [WIDTH-1:0] nb_left;
    logic [WIDTH-1:0] nb_right;

    assign mode_e = bsr_mode_e'(mode);

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        if (i == MSB) begin : g_left_end
            assign nb_left[i] = ser_left_in;
        end else begin : g_left_inner
            assign nb_left[i] = cells_q[i+1];
        end

        if (i == 0) begin : g_right_end
            assign nb_right[i] = ser_right_in;
        end else begin : g_right_inner
            assign nb_right[i] = cells_q[i-1];
        end

        bsr_cell_next u_next (
            .clr        (clr),
            .mode       (mode_e),
            .own_bit    (cells_q[i]),
            .from_left  (nb_left[i]),
            .from_right (nb_right[i]),
            .load_bit   (par_in[i]),
            .next_bit   (cells_d[i])
        );
    end

    bsr_state #(.WIDTH(WIDTH)) u_state (
        .clk       (clk),
        .cells_in  (cells_d),
        .cells_out (cells_q)
    );

    assign par_out       = cells_q;
    assign ser_left_out  = cells_q[MSB];
    assign ser_right_out = cells_q[0];

endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr,
    input logic [1:0]       mode,
    input logic             ser_left_in,
    input logic             ser_right_in,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] par_out,
    input logic             ser_left_out,
    input logic             ser_right_out
);

    localparam int MSB = WIDTH - 1;

    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        if (clr) armed <= 1'b1;
    end

    p_clear_wins_r6: assert property (@(posedge clk) disable iff (!armed)
        clr |=> (par_out == '0));

    p_keep_r2: assert property (@(posedge clk) disable iff (!armed)
        (!clr && mode == 2'b00) |=> $stable(par_out));

    p_move_right_r3: assert property (@(posedge clk) disable iff (!armed)
        (!clr && mode == 2'b01) |=>
            (par_out == {$past(ser_left_in), $past(par_out[MSB:1])}));

    p_move_left_r4: assert property (@(posedge clk) disable iff (!armed)
        (!clr && mode == 2'b10) |=>
            (par_out == {$past(par_out[MSB-1:0]), $past(ser_right_in)}));

    p_take_r5: assert property (@(posedge clk) disable iff (!armed)
        (!clr && mode == 2'b11) |=> (par_out == $past(par_in)));

    p_end_taps_r7: assert property (@(posedge clk) disable iff (!armed)
        (ser_left_out == par_out[MSB]) && (ser_right_out == par_out[0]));

endmodule

bind bidir_shift_reg bsr_checker #(.WIDTH(WIDTH)) u_bsr_checker (
    .clk           (clk),
    .clr           (clr),
    .mode          (mode),
    .ser_left_in   (ser_left_in),
    .ser_right_in  (ser_right_in),
    .par_in        (par_in),
    .par_out       (par_out),
    .ser_left_out  (ser_left_out),
    .ser_right_out (ser_right_out)
);

// File: tb/bidir_shift_reg_test.sv
module bidir_shift_reg_test;

    logic       clk = 1'b0;
    logic       clr = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       sli = 1'b0;
    logic       sri = 1'b0;
    logic [3:0] pin = 4'h0;
    logic [3:0] pout;
    logic       slo;
    logic       sro;

    int   n_checks = 0;
    int   n_fails  = 0;
    logic [3:0] model = 4'h0;

    always #10 clk = ~clk;

    bidir_shift_reg uut (
        .clk           (clk),
        .clr           (clr),
        .mode          (mode),
        .ser_left_in   (sli),
        .ser_right_in  (sri),
        .par_in        (pin),
        .par_out       (pout),
        .ser_left_out  (slo),
        .ser_right_out (sro)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] next_model(input logic [3:0] cur, input logic c,
                                             input logic [1:0] m, input logic l,
                                             input logic r, input logic [3:0] p);
        if (c) return 4'b0000;
        case (m)
            2'b00:   return cur;
            2'b01:   return {l, cur[3:1]};
            2'b10:   return {cur[2:0], r};
            default: return p;
        endcase
    endfunction

    // Drive at a falling edge, pass one rising edge, come back to the falling edge.
    task automatic step(input logic c, input logic [1:0] m, input logic l,
                        input logic r, input logic [3:0] p);
        clr = c; mode = m; sli = l; sri = r; pin = p;
        model = next_model(model, c, m, l, r, p);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_taps(input string req);
        check(req, {3'b000, slo}, {3'b000, model[3]});
        check(req, {3'b000, sro}, {3'b000, model[0]});
    endtask

    task automatic t_clear_state;
        step(1'b1, 2'b00, 1'b0, 1'b0, 4'h0);
        check("R6 clear from power-up", pout, 4'b0000);
    endtask

    task automatic t_take;
        step(1'b0, 2'b11, 1'b0, 1'b0, 4'b1011);
        check("R5 parallel take 1011", pout, 4'b1011);
        check_taps("R7 taps after take");
        step(1'b0, 2'b11, 1'b1, 1'b1, 4'b0110);
        check("R5 parallel take 0110", pout, 4'b0110);
    endtask

    task automatic t_keep;
        step(1'b0, 2'b11, 1'b0, 1'b0, 4'b1001);
        step(1'b0, 2'b00, 1'b1, 1'b0, 4'b0110);
        check("R2 keep ignores inputs", pout, 4'b1001);
        step(1'b0, 2'b00, 1'b0, 1'b1, 4'b1111);
        check("R2 keep second cycle", pout, 4'b1001);
    endtask

    task automatic t_right;
        step(1'b0, 2'b11, 1'b0, 1'b0, 4'b1000);
        step(1'b0, 2'b01, 1'b0, 1'b0, 4'h0);
        check("R3 move right 1000->0100", pout, 4'b0100);
        step(1'b0, 2'b01, 1'b1, 1'b0, 4'h0);
        check("R3 left serial in enters bit3", pout, 4'b1010);
        step(1'b0, 2'b01, 1'b1, 1'b0, 4'h0);
        check("R3 move right again", pout, 4'b1101);
        check_taps("R7 taps during right moves");
        step(1'b0, 2'b01, 1'b0, 1'b1, 4'h0);
        check("R3 right serial in ignored", pout, 4'b0110);
    endtask

    task automatic t_left;
        step(1'b0, 2'b11, 1'b0, 1'b0, 4'b0001);
        step(1'b0, 2'b10, 1'b0, 1'b0, 4'h0);
        check("R4 move left 0001->0010", pout, 4'b0010);
        step(1'b0, 2'b10, 1'b0, 1'b1, 4'h0);
        check("R4 right serial in enters bit0", pout, 4'b0101);
        step(1'b0, 2'b10, 1'b1, 1'b0, 4'h0);
        check("R4 left serial in ignored", pout, 4'b1010);
        check_taps("R7 taps during left moves");
    endtask

    task automatic t_clear_override;
        step(1'b0, 2'b11, 1'b0, 1'b0, 4'b1111);
        step(1'b1, 2'b11, 1'b1, 1'b1, 4'b1111);
        check("R6 clear beats parallel take", pout, 4'b0000);
        step(1'b0, 2'b11, 1'b0, 1'b0, 4'b1010);
        step(1'b1, 2'b01, 1'b1, 1'b1, 4'h0);
        check("R6 clear beats move right", pout, 4'b0000);
    endtask

    task automatic t_edge_only;
        step(1'b0, 2'b11, 1'b0, 1'b0, 4'b0011);
        clr = 1'b0; mode = 2'b11; pin = 4'b1100;
        #5;
        check("R1 no change before rising edge", pout, 4'b0011);
        mode = 2'b01; sli = 1'b1;
        #2;
        check("R1 still no change", pout, 4'b0011);
        model = next_model(model, 1'b0, 2'b01, 1'b1, 1'b0, 4'b1100);
        @(posedge clk);
        @(negedge clk);
        check("R1 change at rising edge", pout, 4'b1001);
    endtask

    task automatic t_mixed;
        for (int k = 0; k < 300; k++) begin
            logic [31:0] rv;
            rv = $urandom;
            step(rv[3:0] == 4'h0, rv[5:4], rv[6], rv[7], rv[11:8]);
            check("R8 mixed sequence vs model", pout, model);
            if (k % 25 == 0) check_taps("R7 taps in mixed sequence");
        end
    endtask

    initial begin : watchdog
        #2000000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        void'($urandom(7));
        @(negedge clk);
        t_clear_state();
        t_take();
        t_keep();
        t_right();
        t_left();
        t_clear_override();
        t_edge_only();
        t_mixed();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule